// File: doc/BRIEF.md
# Programmable Dither Injector

This block sits in front of the word-length reduction stage of a digital audio modulator. For each wide signed sample it builds a pseudo-random value with a roughly triangular distribution, scales it according to a 2-bit level select, adds it to the sample, and then drops the low bits. Adding the noise before the bits are dropped breaks the link between the signal and the truncation error, which is what produces idle tones. The level select trades noise floor against tone suppression. One setting bypasses the noise, and the other three raise the noise power in steps of about 3 dB.

The noise source is a 23-bit maximal-length shift register. It steps once for each accepted sample and holds still between samples, so the noise sequence does not depend on idle gaps. The sum saturates instead of wrapping. The result is registered, and its strobe follows the input strobe by one cycle. The noise-shaping loop and the converter are outside this block.

Parameters: `IN_W` is the input width. `OUT_W` is the output width, and `IN_W` must exceed `OUT_W`. `NZ_W` is the width of each random field, with `2*NZ_W <= 23` and `NZ_W + 1 < IN_W`. `SEED` is the non-zero register value after reset.

Top module: `dither_injector`

## Requirements
- R1: When `lvl_sel` is 00, `out_sample` equals the input sample shifted right arithmetically by `IN_W-OUT_W` bits (floor division). No noise is added.
- R2: The noise register is 23 bits wide. Its next value is `{s[21:0], s[22]^s[17]}`. It is loaded with `SEED` at reset and steps exactly once per cycle in which `in_valid` is high. A sample uses the register value from before its own step. The register is never zero.
- R3: The raw noise is `s[NZ_W-1:0] - s[2*NZ_W-1:NZ_W]`, with both fields read as unsigned. This gives a signed triangular value.
- R4: `lvl_sel` sets the scaling of the raw noise `t`. The value 01 gives `t`. The value 10 gives `t + (t>>>2) + (t>>>3) + (t>>>5)`, which is about ×1.41. The value 11 gives `2*t`. Every shift is arithmetic.
- R5: The scaled noise is added to the full-width sample before the right shift by `IN_W-OUT_W`.
- R6: A shifted sum outside `[-2^(OUT_W-1), 2^(OUT_W-1)-1]` is clamped to the nearest limit and never wraps.
- R7: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `out_sample` updates in that cycle. Otherwise `out_sample` holds its value.
- R8: While reset is held, `out_valid` and `out_sample` are 0.
- R9: `lvl_sel` is sampled together with each strobe, so the level can change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | IN_W | Wide signed sample |
| lvl_sel | input | 2 | Noise level select |
| out_valid | output | 1 | Result strobe |
| out_sample | output | OUT_W | Truncated, saturated signed sample |

## Verification
The bench builds the block with `IN_W=12`, `OUT_W=8` and `NZ_W=4`. The largest scaled noise is then about ±30 input LSBs, which is close to two output LSBs. With these values a sample near either rail saturates at the top level within a few draws. Floor truncation of negative samples and the difference between the three levels show up in single output LSBs. A bit-true model of the shift register in the bench predicts every output. Idle gaps and a mid-run reset are inserted, so any extra or missing step of the register shows up as a mismatch.

// File: rtl/dith_pkg.sv
package dith_pkg;
    localparam int NOISE_REG_W = 23;
    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_MID  = 2'b10,
        LVL_HIGH = 2'b11
    } lvl_e;
endpackage

// File: rtl/dith_noise_reg.sv
module dith_noise_reg #(
    parameter int W    = 23,
    parameter int SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) state_d = {state_q[W-2:0], state_q[22] ^ state_q[17]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W'(SEED);
        else        state_q <= state_d;
    end

    assign state = state_q;

    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));
endmodule

// File: rtl/dith_shape.sv
module dith_shape
    import dith_pkg::*;
#(
    parameter int NZ_W = 4,
    localparam int SC_W = NZ_W + 3
) (
    input  logic [2*NZ_W-1:0]      bits,
    input  logic [1:0]             lvl,
    output logic signed [SC_W-1:0] noise
);
    logic signed [SC_W-1:0] tri_v;

    always_comb begin
        tri_v = $signed({3'b000, bits[NZ_W-1:0]}) - $signed({3'b000, bits[2*NZ_W-1:NZ_W]});
        case (lvl_e'(lvl))
            LVL_LOW:  noise = tri_v;
            LVL_MID:  noise = tri_v + (tri_v >>> 2) + (tri_v >>> 3) + (tri_v >>> 5);
            LVL_HIGH: noise = tri_v <<< 1;
            default:  noise = '0;
        endcase
    end
endmodule

// File: rtl/dith_sat_trunc.sv
module dith_sat_trunc #(
    parameter int SUM_W = 14,
    parameter int SH    = 4,
    parameter int OUT_W = 8
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [OUT_W-1:0]        q
);
    localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MINV = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [SUM_W-1:0] shifted;

    always_comb begin
        shifted = sum >>> SH;
        if (shifted > MAXV)      q = MAXV[OUT_W-1:0];
        else if (shifted < MINV) q = MINV[OUT_W-1:0];
        else                     q = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/dither_injector.sv
module dither_injector
    import dith_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int OUT_W = 16,
    parameter int NZ_W  = 8,
    parameter int SEED  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    input  logic [1:0]       lvl_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);
    localparam int SH    = IN_W - OUT_W;
    localparam int SUM_W = IN_W + 2;
    localparam int SC_W  = NZ_W + 3;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] smp;
    } st_t;

    st_t st_d, st_q;
    logic [NOISE_REG_W-1:0]  nreg;
    logic signed [SC_W-1:0]  noise;
    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        trunc;
    logic unused_nreg;

    assign unused_nreg = ^nreg[NOISE_REG_W-1:2*NZ_W];

    dith_noise_reg #(.W(NOISE_REG_W), .SEED(SEED)) u_nreg (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .state(nreg)
    );

    dith_shape #(.NZ_W(NZ_W)) u_shape (
        .bits(nreg[2*NZ_W-1:0]), .lvl(lvl_sel), .noise(noise)
    );

    assign sum = $signed({{2{in_sample[IN_W-1]}}, in_sample})
               + $signed({{(SUM_W-SC_W){noise[SC_W-1]}}, noise});

    dith_sat_trunc #(.SUM_W(SUM_W), .SH(SH), .OUT_W(OUT_W)) u_sat (
        .sum(sum), .q(trunc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.smp = trunc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_sample = st_q.smp;

    a_r7_strobe_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
    a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lvl_sel == 2'b00) |=> out_sample == $past(in_sample[IN_W-1:SH]));
endmodule

// File: tb/sim_dither_injector.sv
module sim_dither_injector;
    localparam int IN_W = 12, OUT_W = 8, NZ_W = 4, SH = IN_W - OUT_W;
    localparam int OMAX = (1 << (OUT_W-1)) - 1, OMIN = -(1 << (OUT_W-1));

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [IN_W-1:0]  in_sample = '0;
    logic [1:0]       lvl_sel = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_sample;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [22:0] mdl;

    always #10 clk = ~clk;

    dither_injector #(.IN_W(IN_W), .OUT_W(OUT_W), .NZ_W(NZ_W), .SEED(1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .lvl_sel(lvl_sel), .out_valid(out_valid), .out_sample(out_sample)
    );

    // stimulus table: {level, sample}
    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        {2'b00, 12'h000}, {2'b00, 12'hFFF}, {2'b00, 12'h7FF}, {2'b00, 12'h800},
        {2'b01, 12'h000}, {2'b01, 12'h008}, {2'b01, 12'hFF8}, {2'b01, 12'h123},
        {2'b10, 12'h000}, {2'b10, 12'h40F}, {2'b10, 12'hC01}, {2'b10, 12'h7F0},
        {2'b11, 12'h000}, {2'b11, 12'h7FF}, {2'b11, 12'h800}, {2'b11, 12'hA5A}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R6 model
    function automatic int model(input logic [1:0] lvl, input logic [IN_W-1:0] smp, input logic [22:0] s);
        int t, n, sum, q;
        t = int'(s[NZ_W-1:0]) - int'(s[2*NZ_W-1:NZ_W]);
        case (lvl)
            2'b01:   n = t;
            2'b10:   n = t + (t >>> 2) + (t >>> 3) + (t >>> 5);
            2'b11:   n = 2 * t;
            default: n = 0;
        endcase
        sum = int'($signed(smp)) + n;
        q = sum >>> SH;
        if (q > OMAX) q = OMAX;
        if (q < OMIN) q = OMIN;
        return q;
    endfunction

    function automatic int sx(input logic [OUT_W-1:0] v);
        return int'($signed(v));
    endfunction

    // called at a negedge; leaves in_valid high
    task automatic send(input logic [1:0] lvl, input logic [IN_W-1:0] smp, input string req);
        int exp;
        exp = model(lvl, smp, mdl);
        mdl = {mdl[21:0], mdl[22] ^ mdl[17]};
        in_valid = 1; lvl_sel = lvl; in_sample = smp;
        @(negedge clk);
        chk(out_valid === 1'b1, "R7 strobe", int'(out_valid), 1);
        chk(sx(out_sample) == exp, req, sx(out_sample), exp);
    endtask

    task automatic idle(input int n);
        logic [OUT_W-1:0] held;
        held = out_sample;
        in_valid = 0; in_sample = 12'h5A5; lvl_sel = 2'b11;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R7 no strobe", int'(out_valid), 0);
            chk(out_sample === held, "R7 hold", sx(out_sample), sx(held));
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int sat_hits;
        mdl = 23'd1;
        in_valid = 1; in_sample = 12'h7FF; lvl_sel = 2'b11;  // strobe during reset
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R8 valid in reset", int'(out_valid), 0);
        chk(out_sample === '0, "R8 sample in reset", sx(out_sample), 0);
        in_valid = 0;
        rst_n = 1;
        @(negedge clk);

        // R1 explicit: floor truncation of negatives, positive full scale
        send(2'b00, 12'hFF0, "R1 -16 -> -1");
        chk(sx(out_sample) == -1, "R1 floor", sx(out_sample), -1);
        send(2'b00, 12'h00F, "R1 15 -> 0");
        send(2'b00, 12'hFFF, "R1 -1 -> -1");
        idle(2);

        // table walk, back to back; R9 level changes per sample
        for (int i = 0; i < NV; i++)
            send(VEC[i][13:12], VEC[i][11:0], "R4 R5 R9 table");
        idle(1);

        // R2: idle gaps must not step the noise register
        send(2'b01, 12'h100, "R2 before gap");
        idle(7);
        send(2'b01, 12'h100, "R2 after gap");
        idle(1);

        // R6: top level at both rails, count clamps against model
        sat_hits = 0;
        for (int i = 0; i < 30; i++) begin
            if (model(2'b11, 12'h7FF, mdl) == OMAX &&
                ((int'(mdl[3:0]) - int'(mdl[7:4])) * 2 + 2047) >>> SH > OMAX) sat_hits++;
            send(2'b11, 12'h7FF, "R6 top rail");
            chk(sx(out_sample) >= 0, "R6 no wrap high", sx(out_sample), OMAX);
        end
        for (int i = 0; i < 30; i++) begin
            send(2'b11, 12'h800, "R6 bottom rail");
            chk(sx(out_sample) < 0, "R6 no wrap low", sx(out_sample), OMIN);
        end
        chk(sat_hits > 0, "R6 clamp reached", sat_hits, 1);
        idle(1);

        // R3 R4: long mixed run at each level
        for (int i = 0; i < 60; i++)
            send(2'(i % 4), 12'(i * 37 - 900), "R3 R4 mixed");
        idle(1);

        // R8 R2: mid-run reset reloads the seed
        rst_n = 0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 valid after reset", int'(out_valid), 0);
        chk(out_sample === '0, "R8 sample after reset", sx(out_sample), 0);
        rst_n = 1;
        mdl = 23'd1;
        for (int i = 0; i < 8; i++)
            send(2'b11, 12'(i * 5), "R2 seed reload");
        idle(1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule